// File: doc/BRIEF.md
# MII Transmit Nibble Serializer

This block sits on the MAC side of a 4-bit media independent transmit path. It takes frames one byte at a time from an upstream valid/ready stream and puts them on the wire as nibbles. Every output changes on the rising edge of the transmit clock that the PHY supplies. That clock runs at 25 MHz for 100 Mbit/s and at 2.5 MHz for 10 Mbit/s, and the logic is the same at either rate, so the block never needs to know the link speed. Ahead of the payload the block inserts a run of preamble nibbles and then the start-of-frame nibble. Each byte goes out low nibble first, because data bit 0 is the first bit on the wire. The block does not generate the CRC, enforce the inter-frame gap or handle management.

A frame can be cut short in two ways. The upstream can send a beat carrying an abort marker, or it can fail to supply the next byte on time. In either case the block holds the transmit-error line high together with transmit-enable, so the PHY corrupts the frame and no receiver accepts it. When no frame is in progress, a low-power request input puts the interface into the low-power-idle signalling state: enable low, error high and data at 0001. A request that arrives during a frame waits until that frame has ended.

Top module: `mii_tx_serializer`

## Requirements
- R1: While reset is asserted and in the first cycle after it, tx_en and tx_er are low and txd is 0.
- R2: A beat accepted in idle with in_sof set starts a frame. From the next cycle, tx_en is high with txd = 4'h5 for PRE_NIBBLES cycles, followed by one cycle with txd = 4'hD.
- R3: After the start nibble, each accepted byte appears as two nibbles, bits [3:0] first and then bits [7:4]. tx_en stays high through the high nibble of the byte marked in_eof and is low in the following cycle.
- R4: Inside a frame, in_ready is high only in the cycle that shows a byte's high nibble, and not when that byte carried in_eof. It is low during the preamble, the start nibble and the abort nibbles. In idle it equals !lpi_req.
- R5: When a beat with in_abort is accepted inside a frame, its byte is not sent. For the next ABORT_NIBBLES cycles tx_en and tx_er are both high with txd = 0. After that, both go low.
- R6: If in_valid is low in a cycle where the block is ready for the next byte of a frame, that is an underrun, and it ends the frame in the same way as R5.
- R7: With lpi_req high in idle, in_ready is low, and from the next cycle tx_en = 0, tx_er = 1 and txd = 4'b0001, held for as long as the request stays high. One cycle after the request drops, all three outputs are low again.
- R8: An lpi_req raised during a frame does not change that frame. The low-power code appears no earlier than the second cycle after tx_en falls, and the cycle in which tx_en falls has tx_er low.
- R9: A beat presented in idle without in_sof is accepted and discarded. It raises neither tx_en nor tx_er.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Free-running transmit clock from the PHY |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Upstream beat valid |
| in_ready | output | 1 | Block accepts the beat at the next rising edge |
| in_data | input | 8 | Upstream byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| in_abort | input | 1 | Beat carries an abort request; its byte is not sent |
| lpi_req | input | 1 | Request for low-power-idle signalling |
| txd | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit enable |
| tx_er | output | 1 | Transmit error / out-of-frame signalling |

## Verification
The bench builds the block with the full 15-nibble preamble and both the abort and low-power options enabled, so every frame is checked against the real preamble length. ABORT_NIBBLES is raised to 3. This makes a multi-cycle error hold visible, and it means the shared preamble/abort counter must stop at a second, different limit. With these settings, explicit aborts, underruns, deferred low-power requests and ready cadence can all be compared nibble by nibble against frames built from the requirements.

// File: rtl/mii_tx_pkg.sv
package mii_tx_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_PRE   = 3'd1,
      ST_SFD   = 3'd2,
      ST_DATA  = 3'd3,
      ST_ABORT = 3'd4,
      ST_LPI   = 3'd5
   } tx_state_e;

   localparam logic [3:0] NIB_PRE  = 4'h5;
   localparam logic [3:0] NIB_SFD  = 4'hD;
   localparam logic [3:0] NIB_LPI  = 4'b0001;
   localparam logic [3:0] NIB_ZERO = 4'h0;

endpackage

// File: rtl/mii_tx_ctrl.sv
module mii_tx_ctrl
   import mii_tx_pkg::*;
#(
   parameter int PRE_NIBBLES   = 15,
   parameter int ABORT_NIBBLES = 1,
   parameter bit ABORT_EN      = 1'b1,
   parameter bit LPI_EN        = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      in_valid,
   input  logic      in_sof,
   input  logic      in_eof,
   input  logic      in_abort,
   input  logic      lpi_req,
   output logic      in_ready,
   output logic      byte_load,
   output tx_state_e st_nx,
   output logic      hi_nx
);

   localparam int CNT_MAX = (PRE_NIBBLES > ABORT_NIBBLES) ? PRE_NIBBLES : ABORT_NIBBLES;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);
   localparam logic [CNT_W-1:0] PRE_LAST = CNT_W'(PRE_NIBBLES - 1);
   localparam logic [CNT_W-1:0] ABT_LAST = CNT_W'(ABORT_NIBBLES - 1);
   localparam tx_state_e CUT_DEST = ABORT_EN ? ST_ABORT : ST_IDLE;

   tx_state_e        st_q;
   logic [CNT_W-1:0] cnt_q, cnt_nx;
   logic             hi_q;
   logic             eof_q, eof_nx;
   logic             lpi_go;

   // Honour low-power only when the option is built in
   generate
      if (LPI_EN) begin : g_lpi
         assign lpi_go = lpi_req;
      end else begin : g_no_lpi
         assign lpi_go = 1'b0;
      end
   endgenerate

   always_comb begin
      st_nx     = st_q;
      cnt_nx    = cnt_q;
      hi_nx     = hi_q;
      eof_nx    = eof_q;
      in_ready  = 1'b0;
      byte_load = 1'b0;
      case (st_q)
         ST_IDLE: begin
            in_ready = !lpi_go;
            hi_nx    = 1'b0;
            if (lpi_go) begin
               st_nx = ST_LPI;
            end else if (in_valid && in_sof && !in_abort) begin
               st_nx     = ST_PRE;
               cnt_nx    = '0;
               byte_load = 1'b1;
               eof_nx    = in_eof;
            end
         end
         ST_PRE: begin
            if (cnt_q == PRE_LAST) begin
               st_nx = ST_SFD;
            end else begin
               cnt_nx = cnt_q + 1'b1;
            end
         end
         ST_SFD: begin
            st_nx = ST_DATA;
            hi_nx = 1'b0;
         end
         ST_DATA: begin
            if (!hi_q) begin
               hi_nx = 1'b1;
            end else begin
               in_ready = !eof_q;
               hi_nx    = 1'b0;
               if (eof_q) begin
                  st_nx = ST_IDLE;
               end else if (in_valid && !in_abort) begin
                  byte_load = 1'b1;
                  eof_nx    = in_eof;
               end else begin
                  // explicit abort or underrun
                  st_nx  = CUT_DEST;
                  cnt_nx = '0;
               end
            end
         end
         ST_ABORT: begin
            if (cnt_q == ABT_LAST) begin
               st_nx = ST_IDLE;
            end else begin
               cnt_nx = cnt_q + 1'b1;
            end
         end
         ST_LPI: begin
            if (!lpi_go) st_nx = ST_IDLE;
         end
         default: st_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         cnt_q <= '0;
         hi_q  <= 1'b0;
         eof_q <= 1'b0;
      end else begin
         st_q  <= st_nx;
         cnt_q <= cnt_nx;
         hi_q  <= hi_nx;
         eof_q <= eof_nx;
      end
   end

   // R4: inside a frame, ready never holds for two cycles in a row
   assert_ready_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DATA && in_ready) |=> !in_ready);

   // R6: a missing byte at the ready slot sends the frame into abort
   assert_underrun_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ABORT_EN && st_q == ST_DATA && in_ready && !in_valid) |=> (st_q == ST_ABORT));

   // R8: no frame state steps straight into low-power signalling
   assert_lpi_deferred_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q != ST_IDLE && st_q != ST_LPI) |=> (st_q != ST_LPI));

endmodule

// File: rtl/mii_tx_byte_hold.sv
module mii_tx_byte_hold #(
   parameter int NIB_W = 4,
   localparam int BYTE_W = 2 * NIB_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              byte_load,
   input  logic [BYTE_W-1:0] in_data,
   output logic [BYTE_W-1:0] byte_nx
);

   logic [BYTE_W-1:0] byte_q;

   assign byte_nx = byte_load ? in_data : byte_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_nx;
   end

endmodule

// File: rtl/mii_tx_encode.sv
module mii_tx_encode
   import mii_tx_pkg::*;
#(
   parameter int NIB_W    = 4,
   parameter bit ABORT_EN = 1'b1,
   parameter bit LPI_EN   = 1'b1,
   localparam int BYTE_W  = 2 * NIB_W
) (
   input  tx_state_e         st,
   input  logic              hi,
   input  logic [BYTE_W-1:0] byte_v,
   output logic [NIB_W-1:0]  txd_v,
   output logic              en_v,
   output logic              er_v
);

   always_comb begin
      txd_v = NIB_ZERO;
      en_v  = 1'b0;
      case (st)
         ST_PRE: begin
            txd_v = NIB_PRE;
            en_v  = 1'b1;
         end
         ST_SFD: begin
            txd_v = NIB_SFD;
            en_v  = 1'b1;
         end
         ST_DATA: begin
            txd_v = hi ? byte_v[BYTE_W-1:NIB_W] : byte_v[NIB_W-1:0];
            en_v  = 1'b1;
         end
         ST_ABORT: begin
            txd_v = NIB_ZERO;
            en_v  = 1'b1;
         end
         ST_LPI: begin
            txd_v = NIB_LPI;
         end
         default: begin
            txd_v = NIB_ZERO;
         end
      endcase
   end

   // Error line: tied low when neither abort nor low-power is built
   generate
      if (ABORT_EN || LPI_EN) begin : g_er
         assign er_v = (st == ST_ABORT) || (st == ST_LPI);
      end else begin : g_er_tied
         assign er_v = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer
   import mii_tx_pkg::*;
#(
   parameter int NIB_W         = 4,
   parameter int PRE_NIBBLES   = 15,
   parameter int ABORT_NIBBLES = 1,
   parameter bit ABORT_EN      = 1'b1,
   parameter bit LPI_EN        = 1'b1,
   localparam int BYTE_W       = 2 * NIB_W
) (
   input  logic              tx_clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [BYTE_W-1:0] in_data,
   input  logic              in_sof,
   input  logic              in_eof,
   input  logic              in_abort,
   input  logic              lpi_req,
   output logic [NIB_W-1:0]  txd,
   output logic              tx_en,
   output logic              tx_er
);

   generate
      if (NIB_W != 4) begin : g_bad_nib
         $error("mii_tx_serializer: NIB_W must be 4");
      end
      if (PRE_NIBBLES < 1) begin : g_bad_pre
         $error("mii_tx_serializer: PRE_NIBBLES must be at least 1");
      end
      if (ABORT_NIBBLES < 1) begin : g_bad_abt
         $error("mii_tx_serializer: ABORT_NIBBLES must be at least 1");
      end
   endgenerate

   tx_state_e         st_nx;
   logic              hi_nx;
   logic              byte_load;
   logic [BYTE_W-1:0] byte_nx;
   logic [NIB_W-1:0]  txd_nx;
   logic              en_nx, er_nx;

   mii_tx_ctrl #(
      .PRE_NIBBLES   (PRE_NIBBLES),
      .ABORT_NIBBLES (ABORT_NIBBLES),
      .ABORT_EN      (ABORT_EN),
      .LPI_EN        (LPI_EN)
   ) u_ctrl (
      .clk       (tx_clk),
      .rst_n     (rst_n),
      .in_valid  (in_valid),
      .in_sof    (in_sof),
      .in_eof    (in_eof),
      .in_abort  (in_abort),
      .lpi_req   (lpi_req),
      .in_ready  (in_ready),
      .byte_load (byte_load),
      .st_nx     (st_nx),
      .hi_nx     (hi_nx)
   );

   mii_tx_byte_hold #(.NIB_W(NIB_W)) u_hold (
      .clk       (tx_clk),
      .rst_n     (rst_n),
      .byte_load (byte_load),
      .in_data   (in_data),
      .byte_nx   (byte_nx)
   );

   mii_tx_encode #(
      .NIB_W    (NIB_W),
      .ABORT_EN (ABORT_EN),
      .LPI_EN   (LPI_EN)
   ) u_enc (
      .st     (st_nx),
      .hi     (hi_nx),
      .byte_v (byte_nx),
      .txd_v  (txd_nx),
      .en_v   (en_nx),
      .er_v   (er_nx)
   );

   // Outputs come straight from flops loaded with the next-state decode
   always_ff @(posedge tx_clk or negedge rst_n) begin
      if (!rst_n) begin
         txd   <= '0;
         tx_en <= 1'b0;
         tx_er <= 1'b0;
      end else begin
         txd   <= txd_nx;
         tx_en <= en_nx;
         tx_er <= er_nx;
      end
   end

   // R2: every frame opens with a preamble nibble
   assert_frame_opens_pre_R2: assert property (@(posedge tx_clk) disable iff (!rst_n)
      $rose(tx_en) |-> (txd == NIB_PRE));

   // R5: once the error line rises in a frame, clean data never resumes
   assert_abort_sticky_R5: assert property (@(posedge tx_clk) disable iff (!rst_n)
      (tx_en && tx_er) |=> (!tx_en || tx_er));

   // R7: error without enable always carries the low-power code
   assert_lpi_code_R7: assert property (@(posedge tx_clk) disable iff (!rst_n)
      (tx_er && !tx_en) |-> (txd == NIB_LPI));

   // R8: the cycle after a frame ends is a plain idle
   assert_gap_after_frame_R8: assert property (@(posedge tx_clk) disable iff (!rst_n)
      $fell(tx_en) |-> !tx_er);

endmodule

// File: tb/mii_tx_serializer_tb.sv
module mii_tx_serializer_tb;

   localparam int PRE_N = 15;
   localparam int ABT_N = 3;
   localparam int CAP   = 1024;
   localparam int NV    = 10;
   // each entry: {eof, abort, data}
   localparam logic [9:0] VEC [NV] = '{
      {1'b0, 1'b0, 8'h12}, {1'b0, 1'b0, 8'h34}, {1'b1, 1'b0, 8'hAB},
      {1'b1, 1'b0, 8'hF0},
      {1'b0, 1'b0, 8'h5A}, {1'b0, 1'b1, 8'h77},
      {1'b0, 1'b0, 8'h00}, {1'b0, 1'b0, 8'hFF}, {1'b0, 1'b0, 8'hC3}, {1'b1, 1'b0, 8'h3C}
   };

   logic       tx_clk = 1'b0;
   logic       rst_n;
   logic       in_valid, in_ready, in_sof, in_eof, in_abort, lpi_req;
   logic [7:0] in_data;
   logic [3:0] txd;
   logic       tx_en, tx_er;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 0;
   int  mon_n = 0;
   logic [3:0] cap_d [CAP];
   logic       cap_e [CAP];
   logic       cap_r [CAP];
   logic [7:0] exp_bytes [8];

   always #2 tx_clk = ~tx_clk;

   mii_tx_serializer #(
      .PRE_NIBBLES   (PRE_N),
      .ABORT_NIBBLES (ABT_N)
   ) u_dut (
      .tx_clk   (tx_clk),
      .rst_n    (rst_n),
      .in_valid (in_valid),
      .in_ready (in_ready),
      .in_data  (in_data),
      .in_sof   (in_sof),
      .in_eof   (in_eof),
      .in_abort (in_abort),
      .lpi_req  (lpi_req),
      .txd      (txd),
      .tx_en    (tx_en),
      .tx_er    (tx_er)
   );

   // record every in-frame cycle away from the active edge
   always @(negedge tx_clk) begin
      if (tx_en) begin
         cap_d[mon_n % CAP] = txd;
         cap_e[mon_n % CAP] = tx_er;
         cap_r[mon_n % CAP] = in_ready;
         mon_n = mon_n + 1;
      end
   end

   task automatic check(input string req, input int act, input int exp, input string what);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   task automatic push(input logic [7:0] d, input logic s, input logic e, input logic a);
      in_data = d; in_sof = s; in_eof = e; in_abort = a; in_valid = 1'b1;
      #1;
      while (!in_ready) begin
         @(negedge tx_clk);
         #1;
      end
      @(negedge tx_clk);
   endtask

   task automatic drop_valid();
      in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_abort = 1'b0;
   endtask

   task automatic wait_idle();
      while (tx_en) @(negedge tx_clk);
   endtask

   // compare one captured frame with the one the requirements describe
   task automatic verify(input int start, input int nb, input bit ab, input string tag);
      int len;
      len = PRE_N + 1 + 2 * nb + (ab ? ABT_N : 0);
      check(tag, mon_n - start, len, "frame length in nibbles");
      for (int k = 0; k < len; k++) begin
         int         idx;
         int         j;
         logic [3:0] ed;
         logic       ee, er_exp;
         string      rt;
         idx = (start + k) % CAP;
         ee = 1'b0; er_exp = 1'b0;
         if (k < PRE_N) begin
            ed = 4'h5; rt = "R2";
         end else if (k == PRE_N) begin
            ed = 4'hD; rt = "R2";
         end else if (k < PRE_N + 1 + 2 * nb) begin
            j  = k - PRE_N - 1;
            ed = (j % 2 == 1) ? exp_bytes[j / 2][7:4] : exp_bytes[j / 2][3:0];
            rt = "R3";
            er_exp = (j % 2 == 1) && !((j / 2 == nb - 1) && !ab);
         end else begin
            ed = 4'h0; ee = 1'b1; rt = tag;
         end
         check(rt, int'({cap_e[idx], cap_d[idx]}), int'({ee, ed}), "{tx_er,txd}");
         check("R4", int'(cap_r[idx]), int'(er_exp), "in_ready in frame");
      end
   endtask

   initial begin
      repeat (100000) @(posedge tx_clk);
      if (!finished) begin
         finished = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      int fs;
      int start;
      rst_n = 1'b0; lpi_req = 1'b0; in_data = 8'h00;
      drop_valid();
      repeat (3) @(negedge tx_clk);
      check("R1", int'({tx_en, tx_er, txd}), 0, "outputs in reset");
      rst_n = 1'b1;
      @(negedge tx_clk);
      check("R1", int'({tx_en, tx_er, txd}), 0, "outputs after reset");
      check("R4", int'(in_ready), 1, "idle ready");

      // table-driven frames
      fs = 0;
      start = mon_n;
      for (int i = 0; i < NV; i++) begin
         push(VEC[i][7:0], i == fs, VEC[i][9], VEC[i][8]);
         if (VEC[i][9] || VEC[i][8]) begin
            drop_valid();
            wait_idle();
            for (int b = fs; b <= i; b++) exp_bytes[b - fs] = VEC[b][7:0];
            if (VEC[i][8]) verify(start, i - fs, 1'b1, "R5");
            else           verify(start, i - fs + 1, 1'b0, "R3");
            check("R3", int'({tx_en, tx_er}), 0, "idle after frame");
            repeat (3) @(negedge tx_clk);
            fs = i + 1;
            start = mon_n;
         end
      end

      // R9: stray byte in idle
      start = mon_n;
      push(8'h99, 1'b0, 1'b0, 1'b0);
      drop_valid();
      repeat (40) @(negedge tx_clk);
      check("R9", mon_n - start, 0, "tx_en cycles after stray byte");
      check("R9", int'(tx_er), 0, "tx_er after stray byte");

      // R6: underrun after the first byte
      start = mon_n;
      push(8'hA5, 1'b1, 1'b0, 1'b0);
      drop_valid();
      wait_idle();
      exp_bytes[0] = 8'hA5;
      verify(start, 1, 1'b1, "R6");
      repeat (3) @(negedge tx_clk);

      // R7: low-power idle
      lpi_req = 1'b1;
      #1;
      check("R7", int'(in_ready), 0, "ready with low-power request");
      @(negedge tx_clk);
      for (int c = 0; c < 5; c++) begin
         check("R7", int'({tx_en, tx_er, txd}), int'({1'b0, 1'b1, 4'b0001}), "low-power code");
         @(negedge tx_clk);
      end
      lpi_req = 1'b0;
      @(negedge tx_clk);
      check("R7", int'({tx_en, tx_er, txd}), 0, "idle after low-power release");

      // R8: request raised mid-frame
      repeat (2) @(negedge tx_clk);
      start = mon_n;
      push(8'h3E, 1'b1, 1'b0, 1'b0);
      lpi_req = 1'b1;
      push(8'h81, 1'b0, 1'b1, 1'b0);
      drop_valid();
      wait_idle();
      exp_bytes[0] = 8'h3E; exp_bytes[1] = 8'h81;
      verify(start, 2, 1'b0, "R8");
      check("R8", int'(tx_er), 0, "tx_er in cycle tx_en falls");
      @(negedge tx_clk);
      check("R8", int'({tx_en, tx_er, txd}), int'({1'b0, 1'b1, 4'b0001}), "deferred low-power code");
      lpi_req = 1'b0;
      repeat (2) @(negedge tx_clk);
      check("R7", int'({tx_en, tx_er}), 0, "idle at end");

      if (!finished) begin
         finished = 1;
         summary();
         $finish;
      end
   end

endmodule